// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

This block turns characters held in an external transmit FIFO into an asynchronous serial stream on one output line. Every bit boundary is set by a single-cycle baud tick supplied from outside. The block asks the FIFO for a character, waits for the FIFO to confirm the read, and captures the character in its own holding register. It then sends a low start bit, five to eight data bits with the least significant bit first, an optional parity bit in one of four modes, and one or two high stop bits.

A break request can be raised at any time. It takes effect once the stop bits of the current frame have been sent. The line is then held low until a release command arrives, after which the block returns to idle. Configuration inputs are sampled live and must be held steady while a frame is in flight.

Top module: `uart_tx_serializer`

## Requirements
- R1: Coming out of reset, the line output is high (idle) and the read enable is low. With the FIFO empty, the read enable never rises.
- R2: In idle, the read enable is driven for exactly the cycle in which the baud tick is high and the FIFO reports not-empty. From the next cycle the line goes low for one baud period (the start bit).
- R3: If no read-valid pulse arrives before the tick that ends the start bit, the frame is dropped. The line returns high for at least one baud period, and no data bits follow.
- R4: Data bits go out least significant bit first, one per baud period. The count code (0..3) selects 5, 6, 7 or 8 bits. Character bits above the selected count are not sent.
- R5: With parity enabled, one parity bit follows the data bits. Its value is set by the mode code: 0 gives 1 when the number of ones sent is even, 1 gives 1 when that number is odd, 2 gives a constant 0, and 3 gives a constant 1.
- R6: With parity disabled, the stop bits follow the last data bit directly.
- R7: The stop-bit select input chooses one stop bit (0) or two stop bits (1), each high for one baud period.
- R8: A break-start pulse seen during a frame makes the line go low right after the stop bits. The line stays low over any number of baud periods until a break-stop pulse arrives, and then goes high in idle.
- R9: Without a pending break, the line stays high after the stop bits and the block is ready for the next character.
- R10: The character is captured on the read-valid cycle. Changes on the FIFO data input after that cycle have no effect on the frame being sent.
- R11: The line output changes only in the cycle after a baud tick or after a break-stop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse marking each baud period boundary |
| fifoNotEmpty | input | 1 | FIFO holds at least one character |
| fifoRdValid | input | 1 | FIFO confirms the read, data is present |
| fifoRdData | input | MAX_BITS (8) | Character from the FIFO |
| cfgDataBits | input | 2 | Data bit count code: 0..3 for 5..8 bits |
| cfgParityEn | input | 1 | Parity bit enable |
| cfgParityMode | input | 2 | Parity mode: 0 even-ones, 1 odd-ones, 2 forced 0, 3 forced 1 |
| cfgStopTwo | input | 1 | 0 for one stop bit, 1 for two |
| breakStart | input | 1 | Request a held break after the current frame |
| breakStop | input | 1 | Release the break (also cancels a pending request) |
| fifoRdEn | output | 1 | Read request to the FIFO |
| txOut | output | 1 | Serial line output |

## Verification
The bench withholds the read-valid pulse on some requests. A design that does not abandon the frame would then shift out stale or garbage bits instead of returning high. It scrambles the FIFO data bus on every cycle outside the valid pulse, so a design that reads the live bus instead of a captured copy sends corrupted bits. Random frames cover all four bit counts, all four parity codes, both stop lengths, and characters whose upper bits are set under short counts. A wrong parity sense, a missing stop bit or leaked upper bits would each show up as a mismatch at a known baud slot. Break frames hold the line for several periods before release, so a design that released the break early, or entered break with no request, is caught at the first slot after the stop bits.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_BREAK = 3'd5
  } txState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadChar;   // capture FIFO data into holding register
    logic clearOnes;  // reset the ones parity accumulator
    logic addBit;     // fold the current data bit into the accumulator
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int MIN_BITS = 5,
  localparam int IDX_W = $clog2(MAX_BITS),
  localparam int CFG_W = $clog2(MAX_BITS - MIN_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             fifoNotEmpty,
  input  logic             fifoRdValid,
  input  logic [CFG_W-1:0] cfgDataBits,
  input  logic             cfgParityEn,
  input  logic             cfgStopTwo,
  input  logic             breakStart,
  input  logic             breakStop,
  output logic             fifoRdEn,
  output txState_e         state,
  output logic [IDX_W-1:0] bitIdx,
  output txStrobe_t        strobe
);

  txState_e   nextState;
  logic       gotChar;
  logic       breakPend;
  logic       stopCnt;
  logic [IDX_W-1:0] bitLast;

  assign bitLast = IDX_W'(MIN_BITS - 1) + IDX_W'(cfgDataBits);

  assign fifoRdEn = (state == ST_IDLE) && baudTick && fifoNotEmpty;

  always_comb begin
    strobe.loadChar  = (state == ST_START) && fifoRdValid && !gotChar;
    strobe.clearOnes = fifoRdEn;
    strobe.addBit    = (state == ST_DATA) && baudTick;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (fifoRdEn) nextState = ST_START;
      ST_START: if (baudTick) nextState = gotChar ? ST_DATA : ST_IDLE;
      ST_DATA:  if (baudTick && (bitIdx == bitLast))
                  nextState = cfgParityEn ? ST_PAR : ST_STOP;
      ST_PAR:   if (baudTick) nextState = ST_STOP;
      ST_STOP:  if (baudTick && (stopCnt == cfgStopTwo))
                  nextState = breakPend ? ST_BREAK : ST_IDLE;
      ST_BREAK: if (breakStop) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      gotChar   <= 1'b0;
      breakPend <= 1'b0;
      stopCnt   <= 1'b0;
      bitIdx    <= '0;
    end else begin
      state <= nextState;

      if (state != ST_START) gotChar <= 1'b0;
      else if (fifoRdValid)  gotChar <= 1'b1;

      if (breakStop)       breakPend <= 1'b0;
      else if (breakStart) breakPend <= 1'b1;

      if (state != ST_DATA)  bitIdx <= '0;
      else if (baudTick)     bitIdx <= bitIdx + 1'b1;

      if (state != ST_STOP)  stopCnt <= 1'b0;
      else if (baudTick)     stopCnt <= 1'b1;
    end
  end

  // R2: a read request only from idle, and a start bit follows it
  p_read_from_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoRdEn |-> (state == ST_IDLE));
  p_start_after_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoRdEn |=> (state == ST_START));

  // R3: an unconfirmed read never reaches the data bits
  p_abandon_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && baudTick && !gotChar && !fifoRdValid) |=> (state == ST_IDLE));

  // R6: no parity slot when parity is off
  p_no_parity_slot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && !cfgParityEn) |=> (state != ST_PAR));

  // R8: break is held until released
  p_break_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BREAK && !breakStop) |=> (state == ST_BREAK));

  // R9: stop bits end in idle unless a break was pending
  p_stop_to_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_STOP && state != ST_STOP && state != ST_BREAK) |-> (state == ST_IDLE));

endmodule

// File: rtl/uart_tx_dpath.sv
module uart_tx_dpath
  import uart_tx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  localparam int IDX_W = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baudTick,
  input  logic                breakStop,
  input  logic [MAX_BITS-1:0] fifoRdData,
  input  logic [1:0]          cfgParityMode,
  input  txState_e            state,
  input  logic [IDX_W-1:0]    bitIdx,
  input  txStrobe_t           strobe,
  output logic                txOut
);

  logic [MAX_BITS-1:0] holdReg;
  logic                onesOdd;
  logic                parityBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
      onesOdd <= 1'b0;
    end else begin
      if (strobe.loadChar) holdReg <= fifoRdData;
      if (strobe.clearOnes)   onesOdd <= 1'b0;
      else if (strobe.addBit) onesOdd <= onesOdd ^ holdReg[bitIdx];
    end
  end

  always_comb begin
    unique case (cfgParityMode)
      2'b00: parityBit = ~onesOdd;
      2'b01: parityBit = onesOdd;
      2'b10: parityBit = 1'b0;
      default: parityBit = 1'b1;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_START: txOut = 1'b0;
      ST_DATA:  txOut = holdReg[bitIdx];
      ST_PAR:   txOut = parityBit;
      ST_BREAK: txOut = 1'b0;
      default:  txOut = 1'b1;
    endcase
  end

  // R10: the captured character stays put outside the start bit
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_START) |=> $stable(holdReg));

  // R11: the line moves only after a tick or a break release
  p_tx_on_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txOut != $past(txOut)) |-> ($past(baudTick) || $past(breakStop)));

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int MIN_BITS = 5,
  localparam int IDX_W = $clog2(MAX_BITS),
  localparam int CFG_W = $clog2(MAX_BITS - MIN_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baudTick,
  input  logic                fifoNotEmpty,
  input  logic                fifoRdValid,
  input  logic [MAX_BITS-1:0] fifoRdData,
  input  logic [CFG_W-1:0]    cfgDataBits,
  input  logic                cfgParityEn,
  input  logic [1:0]          cfgParityMode,
  input  logic                cfgStopTwo,
  input  logic                breakStart,
  input  logic                breakStop,
  output logic                fifoRdEn,
  output logic                txOut
);

  txState_e         state;
  logic [IDX_W-1:0] bitIdx;
  txStrobe_t        strobe;

  uart_tx_ctrl #(.MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .fifoNotEmpty(fifoNotEmpty), .fifoRdValid(fifoRdValid),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .cfgStopTwo(cfgStopTwo), .breakStart(breakStart), .breakStop(breakStop),
    .fifoRdEn(fifoRdEn), .state(state), .bitIdx(bitIdx), .strobe(strobe)
  );

  uart_tx_dpath #(.MAX_BITS(MAX_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .breakStop(breakStop),
    .fifoRdData(fifoRdData), .cfgParityMode(cfgParityMode),
    .state(state), .bitIdx(bitIdx), .strobe(strobe), .txOut(txOut)
  );

  // R1: idle line right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (txOut && !fifoRdEn));

endmodule

// File: tb/uart_tx_serializer_test.sv
module uart_tx_serializer_test;

  localparam int BAUD_DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick;
  logic       fifoNotEmpty = 1'b0;
  logic       fifoRdValid = 1'b0;
  logic [7:0] fifoRdData = 8'h00;
  logic [1:0] cfgDataBits = 2'd3;
  logic       cfgParityEn = 1'b0;
  logic [1:0] cfgParityMode = 2'd0;
  logic       cfgStopTwo = 1'b0;
  logic       breakStart = 1'b0;
  logic       breakStop = 1'b0;
  logic       fifoRdEn;
  logic       txOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tickCnt = 0;
  logic pendRd = 1'b0;
  logic dropNext = 1'b0;
  logic sawRdEn = 1'b0;
  logic [7:0] fq[$];

  uart_tx_serializer uut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .fifoNotEmpty(fifoNotEmpty), .fifoRdValid(fifoRdValid), .fifoRdData(fifoRdData),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn), .cfgParityMode(cfgParityMode),
    .cfgStopTwo(cfgStopTwo), .breakStart(breakStart), .breakStop(breakStop),
    .fifoRdEn(fifoRdEn), .txOut(txOut)
  );

  always #4 clk = ~clk;

  assign baudTick = (tickCnt == BAUD_DIV - 1);

  // Baud tick source and FIFO model, all updated on the rising edge
  always @(posedge clk) begin
    logic [7:0] popped;
    tickCnt <= (tickCnt == BAUD_DIV - 1) ? 0 : tickCnt + 1;
    if (fifoRdEn) sawRdEn <= 1'b1;
    pendRd <= fifoRdEn;
    fifoRdValid <= 1'b0;
    fifoRdData <= 8'($urandom);
    if (pendRd) begin
      if (dropNext) dropNext <= 1'b0;
      else if (fq.size() != 0) begin
        popped = fq.pop_front();
        fifoRdValid <= 1'b1;
        fifoRdData <= popped;
      end
    end
    fifoNotEmpty <= (fq.size() != 0);
  end

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      finishRun();
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Value on the line over the baud period that ends at the next tick
  task automatic nextSample(output logic v);
    @(negedge clk);
    while (!baudTick) @(negedge clk);
    v = txOut;
  endtask

  task automatic waitStart();
    logic v;
    int guard = 0;
    v = 1'b1;
    while (v == 1'b1 && guard < 60) begin
      nextSample(v);
      guard++;
    end
    check("R2 start bit seen", v, 1'b0);
  endtask

  function automatic logic expParity(input logic [7:0] d, input int n, input logic [1:0] mode);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    case (mode)
      2'd0: return (ones % 2) == 0;
      2'd1: return (ones % 2) == 1;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic runFrame(input logic [7:0] d, input logic [1:0] nCode, input logic pEn,
                          input logic [1:0] pMode, input logic two, input logic drop,
                          input logic brk);
    logic v;
    int n = 5 + int'(nCode);
    @(negedge clk);
    cfgDataBits = nCode; cfgParityEn = pEn; cfgParityMode = pMode; cfgStopTwo = two;
    dropNext = drop;
    fq.push_back(d);
    waitStart();
    if (drop) begin
      nextSample(v);
      check("R3 abandoned frame returns high", v, 1'b1);
      waitStart();
    end
    if (brk) begin
      @(negedge clk); breakStart = 1'b1;
      @(negedge clk); breakStart = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      nextSample(v);
      check("R4/R10 data bit", v, d[i]);
    end
    if (pEn) begin
      nextSample(v);
      check("R5 parity bit", v, expParity(d, n, pMode));
    end
    nextSample(v);
    check("R6/R7 first stop bit", v, 1'b1);
    if (two) begin
      nextSample(v);
      check("R7 second stop bit", v, 1'b1);
    end
    if (brk) begin
      for (int k = 0; k < 3; k++) begin
        nextSample(v);
        check("R8 break held low", v, 1'b0);
      end
      @(negedge clk); breakStop = 1'b1;
      @(negedge clk); breakStop = 1'b0;
      nextSample(v);
      check("R8 line high after release", v, 1'b1);
    end else begin
      nextSample(v);
      check("R9 idle after stop bits", v, 1'b1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 line idle after reset", txOut, 1'b1);
    check("R1 no read after reset", fifoRdEn, 1'b0);
    repeat (20) @(negedge clk);
    check("R1 no read with empty FIFO", sawRdEn, 1'b0);
    check("R11 line stays high while idle", txOut, 1'b1);

    // Directed corner cases
    runFrame(8'hA5, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0); // R4 R6
    runFrame(8'hE0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0); // R4 upper bits dropped, R5 even
    runFrame(8'h07, 2'd1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0); // R5 odd, R7 two stops
    runFrame(8'h3C, 2'd3, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0); // R5 forced 0
    runFrame(8'h00, 2'd2, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0); // R5 forced 1
    runFrame(8'h96, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0); // R3
    runFrame(8'h5A, 2'd3, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1); // R8

    // Constrained random frames
    for (int f = 0; f < 40; f++) begin
      runFrame(8'($urandom), 2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
               ($urandom % 6) == 0, ($urandom % 6) == 0);
    end

    finishRun();
  end

endmodule